// File: doc/BRIEF.md
# Presettable Split Decade Counter

A four-bit decade counter made of two sections that each take their own count clock: a one-bit divide-by-two stage (bit 0 of `cnt_q`) and a three-bit divide-by-five stage (bits 3..1 of `cnt_q`). A chaining input selects how the sections are joined. In BCD chaining the low stage's falling output steps the upper stage, so the counter runs 0 to 9 in plain 8-4-2-1 binary. In bi-quinary chaining the upper stage's falling top bit toggles the low stage, which turns bit 0 into a symmetric divide-by-ten output. In the independent setting each section steps only on its own count clock.

The block lives entirely in one fast system clock domain. Both count clocks and all control and data inputs pass through a synchronizer, and a count happens when a synchronized count clock is seen going from high to low. An active-low clear forces the outputs to zero. An active-low preset copies the data input into both sections and keeps following that input for as long as it is held low. Clear beats preset, and preset beats counting.

Top module: `split_decade_ctr`

## Requirements
- R1: While `clear_n` is low the output `cnt_q` is 0000, whatever `load_n`, `preset_d` and the count clocks do.
- R2: With `clear_n` high and `load_n` low, `cnt_q` equals `preset_d`, and count-clock edges have no effect.
- R3: While `load_n` stays low, a change on `preset_d` shows up on `cnt_q` with no further strobe.
- R4: The count advances only on a high-to-low transition of a count clock; a rising edge or a steady level leaves `cnt_q` unchanged.
- R5: With `chain_sel` = 01 (BCD), each falling edge of `cp_lo` steps `cnt_q` through the binary values 0,1,...,9, then back to 0.
- R6: With `chain_sel` = 10 (bi-quinary), each falling edge of `cp_hi` steps the count c from 0 to 9. `cnt_q[3:1]` = c mod 5 and `cnt_q[0]` = 1 when c is 5 or more, so bit 0 is high for exactly 5 of every 10 counts.
- R7: With `chain_sel` = 00 or 11 (independent), a falling `cp_lo` edge toggles only `cnt_q[0]`. A falling `cp_hi` edge steps only `cnt_q[3:1]`, through 0 to 4 and back to 0.
- R8: In BCD chaining `cp_hi` edges are ignored, and in bi-quinary chaining `cp_lo` edges are ignored.
- R9: If a value of 5, 6 or 7 is preset into `cnt_q[3:1]`, the next step of that section returns it to 000. In a chained mode, that step passes a carry on to the other section.
- R10: A change on any input first shows on `cnt_q` after the third rising system-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the synchronizers and count state |
| cp_lo | input | 1 | Count clock of the divide-by-two section |
| cp_hi | input | 1 | Count clock of the divide-by-five section |
| clear_n | input | 1 | Active-low clear, highest priority |
| load_n | input | 1 | Active-low transparent preset |
| chain_sel | input | 2 | 00/11 independent, 01 BCD, 10 bi-quinary |
| preset_d | input | 4 | Preset value, bit 0 to the low section |
| cnt_q | output | 4 | Counter state, bit 0 low section, bits 3..1 upper section |

## Verification
Every input passes two synchronizer flops, and the counter register comes after them, so a result is due after the third rising system-clock edge following the stimulus (R10). The bench drives inputs on falling clock edges. Its behavioural reference model delays the stimulus through the same number of samples and is compared with `cnt_q` at every falling edge. The targeted checks wait at least four cycles after each count-clock transition before sampling. The latency check samples exactly two and three cycles after a preset change.

// File: rtl/split_decade_ctr_pkg.sv
package split_decade_ctr_pkg;

   typedef enum logic [1:0] {
      CHAIN_FREE = 2'b00,
      CHAIN_BCD  = 2'b01,
      CHAIN_BIQ  = 2'b10,
      CHAIN_FREE2 = 2'b11
   } chain_e;

   function automatic int unsigned width_for(input int unsigned modulus);
      int unsigned w;
      w = 1;
      while ((1 << w) < modulus) w++;
      return w;
   endfunction

endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdc_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdc_fall_det.sv
module sdc_fall_det #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] fall
);
   if (W < 1) begin : g_bad_w
      $error("sdc_fall_det width must be positive");
   end

   logic [W-1:0] prev;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev[i] <= 1'b0;
         else        prev[i] <= lvl[i];
      end
      assign fall[i] = prev[i] & ~lvl[i];

      assert_fall_needs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
         fall[i] |-> $past(lvl[i]) && !lvl[i]);
   end
endmodule

// File: rtl/sdc_lo_stage.sv
module sdc_lo_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic ld,
   input  logic pre_bit,
   input  logic step,
   output logic q,
   output logic wrap_cond
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (clr)   q <= 1'b0;
      else if (ld)    q <= pre_bit;
      else if (step)  q <= ~q;
   end

   assign wrap_cond = q;

   assert_lo_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && step) |=> q != $past(q));
endmodule

// File: rtl/sdc_hi_stage.sv
module sdc_hi_stage #(
   parameter int unsigned MOD = 5,
   parameter int unsigned W   = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] pre,
   input  logic         step,
   output logic [W-1:0] q,
   output logic         wrap_cond
);
   localparam logic [W-1:0] LAST = W'(MOD - 1);

   if (MOD < 2 || (1 << W) < MOD) begin : g_bad_mod
      $error("sdc_hi_stage modulus does not fit its width");
   end

   logic [W-1:0] nxt;

   always_comb begin
      if (q >= LAST) nxt = '0;
      else           nxt = q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (clr)   q <= '0;
      else if (ld)    q <= pre;
      else if (step)  q <= nxt;
   end

   assign wrap_cond = q[W-1] & ~nxt[W-1];

   assert_out_of_range_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && step && q >= LAST) |=> q == '0);
   assert_step_stays_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ld && step) |=> q <= LAST);
endmodule

// File: rtl/split_decade_ctr.sv
module split_decade_ctr
   import split_decade_ctr_pkg::*;
#(
   parameter int unsigned HI_MOD      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned HI_W       = width_for(HI_MOD),
   localparam int unsigned CNT_W      = HI_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cp_lo,
   input  logic             cp_hi,
   input  logic             clear_n,
   input  logic             load_n,
   input  logic [1:0]       chain_sel,
   input  logic [CNT_W-1:0] preset_d,
   output logic [CNT_W-1:0] cnt_q
);
   localparam int unsigned CTL_W = 2 + 2 + CNT_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("split_decade_ctr needs two or more synchronizer stages");
   end

   logic [1:0]       cp_s;
   logic [1:0]       fall;
   logic [CTL_W-1:0] ctl_s;
   logic             clr_n_s, ld_n_s;
   chain_e           chain_s;
   logic [CNT_W-1:0] pre_s;

   sdc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) i_cp_sync (
      .clk(clk), .rst_n(rst_n), .d({cp_hi, cp_lo}), .q(cp_s));

   sdc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({2'b11, {(CTL_W-2){1'b0}}})) i_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({clear_n, load_n, chain_sel, preset_d}), .q(ctl_s));

   assign clr_n_s = ctl_s[CTL_W-1];
   assign ld_n_s  = ctl_s[CTL_W-2];
   assign chain_s = chain_e'(ctl_s[CNT_W+1:CNT_W]);
   assign pre_s   = ctl_s[CNT_W-1:0];

   sdc_fall_det #(.W(2)) i_fall (
      .clk(clk), .rst_n(rst_n), .lvl(cp_s), .fall(fall));

   logic             lo_q, lo_wrap;
   logic [HI_W-1:0]  hi_q;
   logic             hi_wrap;
   logic             lo_step, hi_step;

   always_comb begin
      unique case (chain_s)
         CHAIN_BCD: begin
            lo_step = fall[0];
            hi_step = fall[0] & lo_wrap;
         end
         CHAIN_BIQ: begin
            hi_step = fall[1];
            lo_step = fall[1] & hi_wrap;
         end
         default: begin
            lo_step = fall[0];
            hi_step = fall[1];
         end
      endcase
   end

   sdc_lo_stage i_lo (
      .clk(clk), .rst_n(rst_n), .clr(!clr_n_s), .ld(!ld_n_s),
      .pre_bit(pre_s[0]), .step(lo_step), .q(lo_q), .wrap_cond(lo_wrap));

   sdc_hi_stage #(.MOD(HI_MOD), .W(HI_W)) i_hi (
      .clk(clk), .rst_n(rst_n), .clr(!clr_n_s), .ld(!ld_n_s),
      .pre(pre_s[CNT_W-1:1]), .step(hi_step), .q(hi_q), .wrap_cond(hi_wrap));

   assign cnt_q = {hi_q, lo_q};

   assert_clear_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_s |=> cnt_q == '0);
   assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && !ld_n_s) |=> cnt_q == $past(pre_s));
   assert_hold_without_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && ld_n_s && fall == 2'b00) |=> $stable(cnt_q));
   assert_bcd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && ld_n_s && chain_s == CHAIN_BCD && cnt_q <= CNT_W'(9)) |=> cnt_q <= CNT_W'(9));
   assert_biq_lsb_only_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && ld_n_s && chain_s == CHAIN_BIQ && !(fall[1] && hi_q >= HI_W'(HI_MOD-1))) |=> $stable(lo_q));
   assert_ignored_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && ld_n_s && chain_s == CHAIN_BCD && !fall[0]) |=> $stable(cnt_q));
endmodule

// File: tb/test_split_decade_ctr.sv
module test_split_decade_ctr;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cp_lo = 1'b0, cp_hi = 1'b0, clear_n = 1'b1, load_n = 1'b1;
   logic [1:0] chain_sel = 2'b00;
   logic [3:0] preset_d = 4'h0;
   logic [3:0] cnt_q;

   int checks = 0;
   int fails = 0;
   string cur_req = "R10";

   always #4 clk = ~clk;

   split_decade_ctr i_split_decade_ctr (
      .clk(clk), .rst_n(rst_n), .cp_lo(cp_lo), .cp_hi(cp_hi),
      .clear_n(clear_n), .load_n(load_n), .chain_sel(chain_sel),
      .preset_d(preset_d), .cnt_q(cnt_q));

   // behavioural reference: two sample delays, then edge-driven update
   logic m1_a, m2_a, pa, m1_b, m2_b, pb, m1_c, m2_c, m1_l, m2_l;
   logic [1:0] m1_m, m2_m;
   logic [3:0] m1_p, m2_p;
   int  mhi;
   logic mlo;
   logic f0, f1;

   function automatic int step5(input int v);
      return (v >= 4) ? 0 : v + 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1_a = 0; m2_a = 0; pa = 0; m1_b = 0; m2_b = 0; pb = 0;
         m1_c = 1; m2_c = 1; m1_l = 1; m2_l = 1;
         m1_m = 0; m2_m = 0; m1_p = 0; m2_p = 0;
         mhi = 0; mlo = 0;
      end else begin
         f0 = pa & !m2_a;
         f1 = pb & !m2_b;
         if (!m2_c) begin
            mhi = 0; mlo = 0;
         end else if (!m2_l) begin
            mhi = int'(m2_p[3:1]); mlo = m2_p[0];
         end else begin
            case (m2_m)
               2'b01: if (f0) begin
                  if (mlo) mhi = step5(mhi);
                  mlo = !mlo;
               end
               2'b10: if (f1) begin
                  if (mhi >= 4) mlo = !mlo;
                  mhi = step5(mhi);
               end
               default: begin
                  if (f0) mlo = !mlo;
                  if (f1) mhi = step5(mhi);
               end
            endcase
         end
         pa = m2_a; pb = m2_b;
         m2_a = m1_a; m2_b = m1_b; m2_c = m1_c; m2_l = m1_l; m2_m = m1_m; m2_p = m1_p;
         m1_a = cp_lo; m1_b = cp_hi; m1_c = clear_n; m1_l = load_n; m1_m = chain_sel; m1_p = preset_d;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (cnt_q !== {mhi[2:0], mlo}) begin
            fails++;
            $display("FAIL %s: model compare cnt_q=%b expected %b", cur_req, cnt_q, {mhi[2:0], mlo});
         end
      end
   end

   task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: cnt_q=%b expected %b", tag, got, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_lo();
      cp_lo = 1'b1; wait_n(4); cp_lo = 1'b0; wait_n(4);
   endtask

   task automatic pulse_hi();
      cp_hi = 1'b1; wait_n(4); cp_hi = 1'b0; wait_n(4);
   endtask

   task automatic do_clear();
      clear_n = 1'b0; wait_n(4); clear_n = 1'b1; wait_n(4);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not end, cnt_q=%b expected completion", cnt_q);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int q0_high;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      check("R1 reset state", cnt_q, 4'b0000);

      // BCD order
      cur_req = "R5";
      chain_sel = 2'b01; wait_n(4);
      for (int i = 1; i <= 10; i++) begin
         pulse_lo();
         check("R5 BCD step", cnt_q, 4'(i % 10));
      end
      pulse_lo(); pulse_lo(); pulse_lo();
      cur_req = "R8";
      pulse_hi();
      check("R8 cp_hi ignored in BCD", cnt_q, 4'd3);

      cur_req = "R4";
      cp_lo = 1'b1; wait_n(6);
      check("R4 rising edge no count", cnt_q, 4'd3);
      cp_lo = 1'b0; wait_n(4);
      check("R4 falling edge counts", cnt_q, 4'd4);

      // bi-quinary order
      cur_req = "R6";
      do_clear();
      chain_sel = 2'b10; wait_n(4);
      q0_high = 0;
      for (int c = 1; c <= 10; c++) begin
         pulse_hi();
         check("R6 bi-quinary step", cnt_q, {3'((c % 10) % 5), ((c % 10) >= 5) ? 1'b1 : 1'b0});
         if (cnt_q[0]) q0_high++;
      end
      checks++;
      if (q0_high != 5) begin
         fails++;
         $display("FAIL R6: bit0 high count=%0d expected %0d", q0_high, 5);
      end
      pulse_hi(); pulse_hi();
      cur_req = "R8";
      pulse_lo();
      check("R8 cp_lo ignored in bi-quinary", cnt_q, 4'b0100);

      // independent
      cur_req = "R7";
      chain_sel = 2'b00; do_clear();
      pulse_lo();
      check("R7 lo toggles alone", cnt_q, 4'b0001);
      pulse_lo();
      check("R7 lo toggles back, no carry", cnt_q, 4'b0000);
      for (int k = 1; k <= 5; k++) pulse_hi();
      check("R7 hi wraps mod 5", cnt_q, 4'b0000);
      chain_sel = 2'b11; wait_n(4);
      pulse_hi(); pulse_lo();
      check("R7 code 11 independent", cnt_q, 4'b0011);

      // preset
      cur_req = "R2";
      preset_d = 4'b1011; load_n = 1'b0; wait_n(4);
      check("R2 preset copied", cnt_q, 4'b1011);
      pulse_lo(); pulse_hi();
      check("R2 clocks ignored while loading", cnt_q, 4'b1011);
      cur_req = "R3";
      preset_d = 4'b0110; wait_n(4);
      check("R3 transparent follow", cnt_q, 4'b0110);

      cur_req = "R1";
      clear_n = 1'b0; wait_n(4);
      check("R1 clear beats preset", cnt_q, 4'b0000);
      clear_n = 1'b1; wait_n(4);
      check("R2 preset after clear", cnt_q, 4'b0110);

      // out of range upper section
      cur_req = "R9";
      chain_sel = 2'b00; preset_d = 4'b1110; wait_n(4);
      load_n = 1'b1; wait_n(4);
      check("R9 value 7 loaded", cnt_q, 4'b1110);
      pulse_hi();
      check("R9 value 7 steps to 0", cnt_q, 4'b0000);
      load_n = 1'b0; preset_d = 4'b1011; wait_n(4);
      load_n = 1'b1; chain_sel = 2'b10; wait_n(4);
      pulse_hi();
      check("R9 value 5 wraps with carry in bi-quinary", cnt_q, 4'b0000);
      load_n = 1'b0; preset_d = 4'b1101; wait_n(4);
      load_n = 1'b1; chain_sel = 2'b01; wait_n(4);
      pulse_lo();
      check("R9 value 6 wraps in BCD", cnt_q, 4'b0000);

      // latency
      cur_req = "R10";
      load_n = 1'b0; preset_d = 4'b0000; wait_n(4);
      preset_d = 4'b1001;
      wait_n(2);
      check("R10 not yet after two edges", cnt_q, 4'b0000);
      wait_n(1);
      check("R10 visible after three edges", cnt_q, 4'b1001);
      load_n = 1'b1; wait_n(4);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule